// File: doc/BRIEF.md
# Privilege-Masked Interrupt Pending Logic

This block keeps the pending and enable state for the interrupt sources of one hart running in machine mode. Sources are set one at a time by a post strobe and removed by a clear strobe. A clear-all strobe empties the whole pending set. Software can read both vectors and can overwrite either one in full through its own write port.

Three enable bits taken from the status register build a global mask. Each bit opens one privilege group of software, timer and external sources. A source qualifies when it is pending, enabled and unmasked. The block raises a request when any source qualifies and reports the cause number of the lowest-numbered qualifying source. Trap entry, delegation and vectoring are left to the surrounding core.

Top module: `irq_pend_mask`

## Requirements
- R1: After reset, the pending and enable vectors read zero, `irq_req` and `cause_valid` are low, and `cause_id` is 0.
- R2: A post strobe with a cause number from 0 to 11 sets that pending bit at the next clock edge. A cause number from 12 to 15 leaves the pending vector unchanged.
- R3: A clear strobe with a cause number clears that pending bit. When a post and a clear name the same bit in one cycle, the bit ends up cleared. When they name different bits, each takes effect.
- R4: A clear-all strobe zeros the pending vector and leaves the enable vector unchanged.
- R5: `pend_we` loads `pend_wdata` into the pending vector, and `en_we` loads `en_wdata` into the enable vector. A pending write overrides any post, clear or clear-all in the same cycle.
- R6: `st_m_en` unmasks bits 3, 7 and 11. `st_s_en` unmasks bits 1, 5 and 9. `st_u_en` unmasks bits 0, 4 and 8. Bits 2, 6 and 10 are never unmasked.
- R7: `irq_req` is high exactly when some bit is pending, enabled and unmasked.
- R8: `cause_id` is the lowest qualifying bit index, and `cause_valid` is high with it. When no bit qualifies, `cause_id` is 0 and `cause_valid` is low.
- R9: The request outputs follow the registered vectors and the status bits combinationally. A change in the status bits shows on them in the same cycle, and a register update shows in the cycle after its clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| post_stb | input | 1 | Set one pending bit |
| post_cause | input | 4 | Cause number to set |
| clr_stb | input | 1 | Clear one pending bit |
| clr_cause | input | 4 | Cause number to clear |
| clr_all | input | 1 | Zero the whole pending vector |
| pend_we | input | 1 | Full write of the pending vector |
| pend_wdata | input | 12 | Pending write data |
| en_we | input | 1 | Full write of the enable vector |
| en_wdata | input | 12 | Enable write data |
| st_m_en | input | 1 | Machine group enable from status |
| st_s_en | input | 1 | Supervisor group enable from status |
| st_u_en | input | 1 | User group enable from status |
| pend_q | output | 12 | Pending vector read value |
| en_q | output | 12 | Enable vector read value |
| irq_req | output | 1 | Some source can be taken |
| cause_valid | output | 1 | `cause_id` holds a qualifying cause |
| cause_id | output | 4 | Selected cause number |

## Verification
The assertions take it that inputs are stable and known at each rising edge, and that a cause number outside 0 to 11 is meant to be ignored and is not an error. They check the post, clear and write effects only when no higher-priority update claims the same cycle. The stimulus changes every input on the falling edge and releases the strobes after one edge. It walks all 4096 pending patterns under all eight status combinations and all 4096 enable patterns, so every mask case is reached without timing overlap.

// File: rtl/irq_pend_mask.sv
module irq_pend_mask #(
  parameter int NSRC = 12,
  parameter int CW   = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            post_stb,
  input  logic [CW-1:0]   post_cause,
  input  logic            clr_stb,
  input  logic [CW-1:0]   clr_cause,
  input  logic            clr_all,
  input  logic            pend_we,
  input  logic [NSRC-1:0] pend_wdata,
  input  logic            en_we,
  input  logic [NSRC-1:0] en_wdata,
  input  logic            st_m_en,
  input  logic            st_s_en,
  input  logic            st_u_en,
  output logic [NSRC-1:0] pend_q,
  output logic [NSRC-1:0] en_q,
  output logic            irq_req,
  output logic            cause_valid,
  output logic [CW-1:0]   cause_id
);

  localparam logic [NSRC-1:0] GRP_U = NSRC'((1 << 0) | (1 << 4) | (1 << 8));
  localparam logic [NSRC-1:0] GRP_S = NSRC'((1 << 1) | (1 << 5) | (1 << 9));
  localparam logic [NSRC-1:0] GRP_M = NSRC'((1 << 3) | (1 << 7) | (1 << 11));
  localparam logic [CW:0]     LIMIT = (CW+1)'(NSRC);

  logic [NSRC-1:0] post_oh, clr_oh, pend_d, gmask, qual;

  assign post_oh = ({1'b0, post_cause} < LIMIT) ? (NSRC'(1) << post_cause) : '0;
  assign clr_oh  = ({1'b0, clr_cause}  < LIMIT) ? (NSRC'(1) << clr_cause)  : '0;

  always_comb begin
    pend_d = pend_q;
    if (post_stb) pend_d = pend_d | post_oh;
    if (clr_stb)  pend_d = pend_d & ~clr_oh;
    if (clr_all)  pend_d = '0;
    if (pend_we)  pend_d = pend_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= '0;
      en_q   <= '0;
    end else begin
      pend_q <= pend_d;
      if (en_we) en_q <= en_wdata;
    end
  end

  assign gmask = ({NSRC{st_m_en}} & GRP_M) | ({NSRC{st_s_en}} & GRP_S) |
                 ({NSRC{st_u_en}} & GRP_U);
  assign qual  = pend_q & en_q & gmask;

  always_comb begin
    cause_id = '0;
    for (int i = NSRC - 1; i >= 0; i--)
      if (qual[i]) cause_id = CW'(i);
  end

  assign irq_req     = |qual;
  assign cause_valid = irq_req;

  logic post_alone;
  assign post_alone = post_stb && !pend_we && !clr_all && !(clr_stb && clr_cause == post_cause);

  // R2
  post_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    post_alone |=> ((pend_q & $past(post_oh)) == $past(post_oh)));

  // R3
  clr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_stb && !pend_we) |=> ((pend_q & $past(clr_oh)) == '0));

  // R4
  clr_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_all && !pend_we && !en_we) |=> (pend_q == '0 && $stable(en_q)));

  // R5
  pend_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend_we |=> (pend_q == $past(pend_wdata)));

  // R8
  cause_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cause_valid |-> (pend_q[cause_id] && en_q[cause_id]));

  // R8
  idle_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cause_valid |-> (cause_id == '0));

endmodule

// File: tb/irq_pend_mask_bench.sv
module irq_pend_mask_bench;
  localparam int CLK_P = 10;

  logic clk = 0, rst_n = 0;
  logic post_stb = 0, clr_stb = 0, clr_all = 0, pend_we = 0, en_we = 0;
  logic [3:0] post_cause = 0, clr_cause = 0;
  logic [11:0] pend_wdata = 0, en_wdata = 0;
  logic st_m_en = 0, st_s_en = 0, st_u_en = 0;
  logic [11:0] pend_q, en_q;
  logic irq_req, cause_valid;
  logic [3:0] cause_id;
  int checks = 0, fails = 0;

  always #(CLK_P/2) clk = ~clk;

  irq_pend_mask u_irq_pend_mask (
    .clk(clk), .rst_n(rst_n), .post_stb(post_stb), .post_cause(post_cause),
    .clr_stb(clr_stb), .clr_cause(clr_cause), .clr_all(clr_all),
    .pend_we(pend_we), .pend_wdata(pend_wdata), .en_we(en_we), .en_wdata(en_wdata),
    .st_m_en(st_m_en), .st_s_en(st_s_en), .st_u_en(st_u_en),
    .pend_q(pend_q), .en_q(en_q), .irq_req(irq_req),
    .cause_valid(cause_valid), .cause_id(cause_id));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    post_stb = 0; clr_stb = 0; clr_all = 0; pend_we = 0; en_we = 0;
  endtask

  task automatic wr_pend(input logic [11:0] v);
    pend_we = 1; pend_wdata = v; step();
  endtask

  task automatic wr_en(input logic [11:0] v);
    en_we = 1; en_wdata = v; step();
  endtask

  function automatic logic [11:0] grp_mask(input int st);
    logic [11:0] m = 0;
    if (st[2]) m = m | 12'h888;
    if (st[1]) m = m | 12'h222;
    if (st[0]) m = m | 12'h111;
    return m;
  endfunction

  task automatic check_out(input string req, input logic [11:0] p, input logic [11:0] e, input int st);
    logic [11:0] q;
    int lo;
    q = p & e & grp_mask(st);
    lo = 0;
    for (int i = 11; i >= 0; i--) if (q[i]) lo = i;
    chk({req, " irq_req"}, int'(irq_req), int'(q != 0));
    chk({req, " cause_valid"}, int'(cause_valid), int'(q != 0));
    chk({req, " cause_id"}, int'(cause_id), lo);
  endtask

  initial begin
    #(CLK_P * 200000);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    @(negedge clk); step(); step();
    // R1 reset state
    chk("R1 pend", int'(pend_q), 0);
    chk("R1 en", int'(en_q), 0);
    chk("R1 irq", int'(irq_req), 0);
    chk("R1 valid", int'(cause_valid), 0);
    chk("R1 cause", int'(cause_id), 0);
    rst_n = 1;
    step();

    // R2 post every cause number, out of range ignored
    for (int c = 0; c < 16; c++) begin
      wr_pend(12'h000);
      post_stb = 1; post_cause = 4'(c); step();
      chk("R2 post", int'(pend_q), (c < 12) ? (1 << c) : 0);
    end

    // R3 clear each bit, clear beats post, distinct bits both apply
    for (int c = 0; c < 12; c++) begin
      wr_pend(12'hFFF);
      clr_stb = 1; clr_cause = 4'(c); step();
      chk("R3 clear", int'(pend_q), int'(12'hFFF & ~(12'(1) << c)));
    end
    wr_pend(12'h000);
    post_stb = 1; post_cause = 5; clr_stb = 1; clr_cause = 5; step();
    chk("R3 same bit", int'(pend_q), 0);
    wr_pend(12'h004);
    post_stb = 1; post_cause = 7; clr_stb = 1; clr_cause = 2; step();
    chk("R3 distinct bits", int'(pend_q), 12'h080);

    // R4 clear-all keeps enables
    wr_en(12'hA5A);
    wr_pend(12'hFFF);
    clr_all = 1; step();
    chk("R4 pend zero", int'(pend_q), 0);
    chk("R4 en kept", int'(en_q), 12'hA5A);

    // R5 pending write overrides strobes; enable write
    wr_pend(12'h00F);
    pend_we = 1; pend_wdata = 12'h3C1; post_stb = 1; post_cause = 2;
    clr_stb = 1; clr_cause = 0; clr_all = 1; step();
    chk("R5 write wins", int'(pend_q), 12'h3C1);
    wr_en(12'h5A5);
    chk("R5 en write", int'(en_q), 12'h5A5);

    // R9 status change visible in same cycle, no clock needed
    wr_en(12'hFFF);
    wr_pend(12'h008);
    st_m_en = 0; #1;
    chk("R9 masked", int'(irq_req), 0);
    st_m_en = 1; #1;
    chk("R9 unmasked", int'(irq_req), 1);
    chk("R9 cause", int'(cause_id), 3);
    @(negedge clk);

    // R6 R7 R8 sweep all pending patterns under all status codes
    for (int st = 0; st < 8; st++) begin
      st_m_en = st[2]; st_s_en = st[1]; st_u_en = st[0];
      for (int p = 0; p < 4096; p++) begin
        wr_pend(12'(p));
        check_out("R6 R7 R8 pend sweep", 12'(p), 12'hFFF, st);
      end
    end

    // R6 R7 R8 sweep all enable patterns
    st_m_en = 1; st_s_en = 1; st_u_en = 1;
    wr_pend(12'hFFF);
    for (int e = 0; e < 4096; e++) begin
      wr_en(12'(e));
      check_out("R6 R7 R8 en sweep", 12'hFFF, 12'(e), 7);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule